// File: doc/BRIEF.md
# SDRAM Burst Read Sequencer

The block turns one read request into a four-beat SDRAM read with auto-precharge, on a 32-bit data path made of two 16-bit devices side by side. An accepted request opens a row with an activate command. The next cycle issues a read command that asks for auto-precharge. In each of the four cycles after that, the block samples one 32-bit word on the falling clock edge and passes it to the requester with a ready pulse.

The word address is split into column, bank and row fields. The split depends on a multiplex code. After the last data cycle the bank just read is locked for a configured number of precharge-wait cycles. A request to the other bank can be accepted at once. A request that carries a reserved multiplex code is refused with an error flag and sends no command to the memory.

A requester holds `req` and its configuration steady until `req_ack` or `req_err` is high. It then drops `req` in the next cycle.

Top module: `sdram_burst_rd`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after reset, the command pins read NOP (`sd_ras_n`,`sd_cas_n`,`sd_we_n` = 1,1,1), and `rd_rdy`, `rd_done` and `req_ack` are low.
- R2: A request with a legal code, made while the sequencer is idle and the target bank is unlocked, raises `req_ack` combinationally in the same cycle. The next cycle carries the activate command (0,1,1).
- R3: The cycle after an activate carries the read command (1,0,1). In that cycle `sd_a` holds the column bits in its low positions and zeros above them, and the top pin `sd_a[12]` is 1 to request auto-precharge.
- R4: The code sets the column width C: 000→8, 001→9, 010→10, 011→11, 111→7. The bank is `addr[C]`. The row is `addr[C+13:C+1]`, and it is driven on `sd_a` during the activate cycle. `sd_ba` carries the bank during both command cycles.
- R5: The block samples `sd_dq` on the falling edge of each of the four cycles that follow the read command. Each word appears on `rd_data`, with `rd_rdy` high, in the cycle after the one in which it was sampled. The words arrive in sampling order.
- R6: `rd_done` is high for exactly one cycle, together with the fourth `rd_rdy`.
- R7: Every cycle that carries neither an activate nor a read command drives NOP, including the four data cycles.
- R8: Codes 100, 101 and 110 are reserved. When `cfg_wide` is 0, codes 001 and 010 are reserved too. A request with a reserved code raises `req_err` and not `req_ack` in the same cycle, and the next cycle is NOP.
- R9: After the last data cycle, the bank just read is locked for `cfg_trp`+1 cycles. A request to that bank, held from the first cycle after the last data cycle, is acknowledged in cycle `cfg_trp`+2 counted from the last data cycle.
- R10: A request to the other bank, made in the first cycle after the last data cycle, is acknowledged in that cycle, and its activate follows in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; data sampled on the falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Read request, held until acknowledged or refused |
| addr | input | 25 | Word address of the burst |
| cfg_wide | input | 1 | Bus-width bit; 0 reserves codes 001 and 010 |
| cfg_mux | input | 3 | Address multiplex code |
| cfg_trp | input | 2 | Precharge wait, value+1 cycles |
| req_ack | output | 1 | Request accepted this cycle |
| req_err | output | 1 | Request refused, reserved code |
| rd_rdy | output | 1 | `rd_data` valid this cycle |
| rd_data | output | 32 | Captured data word |
| rd_done | output | 1 | Last word of the burst |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_a | output | 13 | Multiplexed address pins |
| sd_dq | input | 32 | Data from the two devices |

## Verification
Let cycle 0 be the cycle in which a request is presented. `req_ack` or `req_err` is due in cycle 0, the activate in cycle 1 and the read in cycle 2. The bench drives a data word in each of cycles 3 to 6 and expects it back on `rd_data` one cycle later, in cycles 4 to 7, with `rd_done` in cycle 7. A same-bank request held from cycle 7 must be acknowledged in cycle 8 + `cfg_trp`. A request to the other bank must be acknowledged in cycle 7 itself. Each check runs one clock edge at a time: inputs change 1 ns after a rising edge, and outputs are sampled 8 ns after it, so every expected value is pinned to a single cycle.

// File: rtl/sdram_burst_rd.sv
module sdram_burst_rd #(
  parameter int ROW_W = 13,
  parameter int DW    = 32,
  parameter int BEATS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic [ROW_W+11:0] addr,
  input  logic             cfg_wide,
  input  logic [2:0]       cfg_mux,
  input  logic [1:0]       cfg_trp,
  output logic             req_ack,
  output logic             req_err,
  output logic             rd_rdy,
  output logic [DW-1:0]    rd_data,
  output logic             rd_done,
  output logic             sd_ras_n,
  output logic             sd_cas_n,
  output logic             sd_we_n,
  output logic             sd_ba,
  output logic [ROW_W-1:0] sd_a,
  input  logic [DW-1:0]    sd_dq
);
  localparam int AW  = ROW_W + 12;
  localparam int CPW = ROW_W - 1;
  localparam int BCW = (BEATS > 1) ? $clog2(BEATS) : 1;

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_COL, S_DAT} st_t;

  function automatic logic [3:0] col_w(input logic [2:0] m);
    case (m)
      3'b001:  return 4'd9;
      3'b010:  return 4'd10;
      3'b011:  return 4'd11;
      3'b111:  return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic code_ok(input logic w, input logic [2:0] m);
    case (m)
      3'b000, 3'b011, 3'b111: return 1'b1;
      3'b001, 3'b010:         return w;
      default:                return 1'b0;
    endcase
  endfunction

  st_t              st;
  logic [BCW-1:0]   bcnt;
  logic [ROW_W-1:0] row_q;
  logic [CPW-1:0]   col_q;
  logic             ba_q;
  logic [1:0]       tp_q;
  logic [DW-1:0]    dq_q;
  logic [2:0]       lk [2];

  logic [3:0]       cw_in;
  logic             bank_in, ok_in, idle, last_beat;
  logic [ROW_W-1:0] row_in;
  logic [CPW-1:0]   col_in;
  logic [AW-1:0]    shifted;

  assign idle      = (st == S_IDLE);
  assign last_beat = (st == S_DAT) && (bcnt == BCW'(BEATS - 1));
  assign cw_in     = col_w(cfg_mux);
  assign ok_in     = code_ok(cfg_wide, cfg_mux);
  assign bank_in   = addr[cw_in];
  assign shifted   = addr >> (cw_in + 4'd1);
  assign row_in    = shifted[ROW_W-1:0];

  always_comb begin
    for (int i = 0; i < CPW; i++)
      col_in[i] = (i < int'(cw_in)) ? addr[i] : 1'b0;
  end

  assign req_ack  = req && idle && ok_in && (lk[bank_in] == 3'd0);
  assign req_err  = req && idle && !ok_in;

  assign sd_ras_n = (st != S_ACT);
  assign sd_cas_n = (st != S_COL);
  assign sd_we_n  = 1'b1;
  assign sd_ba    = ba_q;
  assign sd_a     = (st == S_ACT) ? row_q :
                    (st == S_COL) ? {1'b1, col_q} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      bcnt    <= '0;
      row_q   <= '0;
      col_q   <= '0;
      ba_q    <= 1'b0;
      tp_q    <= 2'd0;
      rd_rdy  <= 1'b0;
      rd_done <= 1'b0;
      rd_data <= '0;
    end else begin
      rd_rdy  <= (st == S_DAT);
      rd_done <= last_beat;
      if (st == S_DAT) rd_data <= dq_q;
      case (st)
        S_IDLE: if (req_ack) begin
          st    <= S_ACT;
          row_q <= row_in;
          col_q <= col_in;
          ba_q  <= bank_in;
          tp_q  <= cfg_trp;
        end
        S_ACT: st <= S_COL;
        S_COL: begin
          st   <= S_DAT;
          bcnt <= '0;
        end
        default: begin
          bcnt <= bcnt + BCW'(1);
          if (last_beat) st <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n)             dq_q <= '0;
    else if (st == S_DAT)   dq_q <= sd_dq;
  end

  for (genvar b = 0; b < 2; b++) begin : g_lock
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 lk[b] <= 3'd0;
      else if (last_beat && (ba_q == 1'(b)))      lk[b] <= {1'b0, tp_q} + 3'd1;
      else if (lk[b] != 3'd0)                     lk[b] <= lk[b] - 3'd1;
    end
  end
endmodule

// File: rtl/sdram_burst_rd_chk.sv
module sdram_burst_rd_chk #(
  parameter int ROW_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ack,
  input logic             req_err,
  input logic             rd_rdy,
  input logic             rd_done,
  input logic             sd_ras_n,
  input logic             sd_cas_n,
  input logic             sd_we_n,
  input logic             sd_ba,
  input logic [ROW_W-1:0] sd_a
);
  logic act, rdc, nop, last_ba, seen, done_d;
  assign act = !sd_ras_n &&  sd_cas_n && sd_we_n;
  assign rdc =  sd_ras_n && !sd_cas_n && sd_we_n;
  assign nop =  sd_ras_n &&  sd_cas_n && sd_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_ba <= 1'b0;
      seen    <= 1'b0;
      done_d  <= 1'b0;
    end else begin
      done_d <= rd_done;
      if (act) begin
        last_ba <= sd_ba;
        seen    <= 1'b1;
      end
    end
  end

  AST_ACK_ERR_EXCL:  assert property (@(posedge clk) disable iff (!rst_n) !(req_ack && req_err));           // R8
  AST_ERR_NO_CMD:    assert property (@(posedge clk) disable iff (!rst_n) req_err |=> nop);                  // R8
  AST_ACK_ACTIVATE:  assert property (@(posedge clk) disable iff (!rst_n) req_ack |=> act);                  // R2
  AST_ACT_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n) act |=> rdc);                      // R3
  AST_READ_AUTOPRE:  assert property (@(posedge clk) disable iff (!rst_n) rdc |-> sd_a[ROW_W-1]);            // R3
  AST_ONE_COMMAND:   assert property (@(posedge clk) disable iff (!rst_n) $onehot0({act, rdc}) && sd_we_n);  // R7
  AST_DONE_WITH_RDY: assert property (@(posedge clk) disable iff (!rst_n) rd_done |-> rd_rdy);               // R6
  AST_DONE_SINGLE:   assert property (@(posedge clk) disable iff (!rst_n) rd_done |=> !rd_done);             // R6
  AST_BANK_LOCKOUT:  assert property (@(posedge clk) disable iff (!rst_n)
                       (act && seen && sd_ba == last_ba) |-> (!rd_done && !done_d));                        // R9
endmodule

bind sdram_burst_rd sdram_burst_rd_chk #(.ROW_W(ROW_W)) u_chk (.*);

// File: tb/sim_sdram_burst_rd.sv
module sim_sdram_burst_rd;
  localparam int ROW_W = 13;
  localparam int AW    = ROW_W + 12;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, cfg_wide = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [2:0] cfg_mux = '0;
  logic [1:0] cfg_trp = '0;
  logic [31:0] sd_dq = '0, rd_data;
  logic req_ack, req_err, rd_rdy, rd_done, sd_ras_n, sd_cas_n, sd_we_n, sd_ba;
  logic [ROW_W-1:0] sd_a;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  sdram_burst_rd u0 (.*);

  localparam logic [31:0] VEC [10] = '{
    {1'b1, 3'b000, 2'd0, 25'h0ABCDE5, 1'b0},
    {1'b1, 3'b001, 2'd1, 25'h1234567, 1'b0},
    {1'b1, 3'b010, 2'd2, 25'h0F0F0F3, 1'b0},
    {1'b1, 3'b011, 2'd3, 25'h1FFFFFF, 1'b0},
    {1'b0, 3'b111, 2'd0, 25'h0155AA9, 1'b0},
    {1'b0, 3'b000, 2'd1, 25'h1A5A5A5, 1'b0},
    {1'b0, 3'b001, 2'd0, 25'h0000123, 1'b1},
    {1'b1, 3'b100, 2'd0, 25'h0000456, 1'b1},
    {1'b1, 3'b110, 2'd2, 25'h0000789, 1'b1},
    {1'b0, 3'b010, 2'd3, 25'h0000ABC, 1'b1}
  };

  task automatic chk(input logic ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  function automatic int ecw(input logic [2:0] m);
    case (m)
      3'b001: return 9;
      3'b010: return 10;
      3'b011: return 11;
      3'b111: return 7;
      default: return 8;
    endcase
  endfunction

  function automatic logic [31:0] pat(input logic [AW-1:0] a, input int i);
    return (32'(a) * 32'd3) ^ (32'h0101_0101 * 32'(i + 1)) ^ 32'hC0DE_0000;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  // follow: 0 = same-bank request after the burst, 1 = other-bank request
  task automatic run_vec(input logic w, input logic [2:0] m, input logic [1:0] tp,
                         input logic [AW-1:0] a, input logic experr, input int follow);
    int cw = ecw(m);
    logic bank = a[cw];
    logic [AW-1:0] sh = a >> (cw + 1);
    logic [ROW_W-1:0] row = sh[ROW_W-1:0];
    logic [ROW_W-2:0] col = (ROW_W-1)'(a & ((25'd1 << cw) - 25'd1));
    step(); req = 1; cfg_wide = w; cfg_mux = m; cfg_trp = tp; addr = a; #7;
    if (experr) begin
      chk(req_err === 1'b1, "R8 err", 64'(req_err), 1);
      chk(req_ack === 1'b0, "R8 ack", 64'(req_ack), 0);
      step(); req = 0; #7;
      chk({sd_ras_n, sd_cas_n, sd_we_n} === 3'b111, "R8 nop", 64'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
      return;
    end
    chk(req_ack === 1'b1, "R2 ack", 64'(req_ack), 1);
    step(); req = 0; #7;
    chk({sd_ras_n, sd_cas_n, sd_we_n} === 3'b011, "R2 act", 64'({sd_ras_n, sd_cas_n, sd_we_n}), 3);
    chk(sd_a === row, "R4 row", 64'(sd_a), 64'(row));
    chk(sd_ba === bank, "R4 bank", 64'(sd_ba), 64'(bank));
    step(); #7;
    chk({sd_ras_n, sd_cas_n, sd_we_n} === 3'b101, "R3 read", 64'({sd_ras_n, sd_cas_n, sd_we_n}), 5);
    chk(sd_a === {1'b1, col}, "R3 col", 64'(sd_a), 64'({1'b1, col}));
    chk(sd_ba === bank, "R4 bank col", 64'(sd_ba), 64'(bank));
    for (int i = 0; i < 4; i++) begin
      step(); sd_dq = pat(a, i); #7;
      chk({sd_ras_n, sd_cas_n, sd_we_n} === 3'b111, "R7 nop", 64'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
      chk(rd_rdy === (i != 0), "R5 rdy", 64'(rd_rdy), 64'(i != 0));
      chk(rd_done === 1'b0, "R6 early", 64'(rd_done), 0);
      if (i != 0) chk(rd_data === pat(a, i - 1), "R5 data", 64'(rd_data), 64'(pat(a, i - 1)));
    end
    step(); sd_dq = '0; req = 1;
    addr = follow ? (a ^ (25'd1 << cw)) : a; #7;
    chk(rd_rdy === 1'b1, "R5 rdy4", 64'(rd_rdy), 1);
    chk(rd_data === pat(a, 3), "R5 data4", 64'(rd_data), 64'(pat(a, 3)));
    chk(rd_done === 1'b1, "R6 done", 64'(rd_done), 1);
    if (follow) begin
      chk(req_ack === 1'b1, "R10 ack", 64'(req_ack), 1);
      step(); req = 0; #7;
      chk(!sd_ras_n && sd_cas_n && sd_ba === !bank, "R10 act", 64'({sd_ras_n, sd_ba}), 64'({1'b0, !bank}));
    end else begin
      chk(req_ack === 1'b0, "R9 lock", 64'(req_ack), 0);
      for (int j = 1; j <= int'(tp) + 1; j++) begin
        step(); #7;
        chk(req_ack === (j == int'(tp) + 1), "R9 wait", 64'(req_ack), 64'(j == int'(tp) + 1));
        chk(rd_done === 1'b0, "R6 single", 64'(rd_done), 0);
      end
      step(); req = 0;
    end
    repeat (14) @(posedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #3;
    chk({sd_ras_n, sd_cas_n, sd_we_n} === 3'b111, "R1 nop", 64'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
    repeat (3) @(posedge clk);
    #1 rst_n = 1; #7;
    chk({sd_ras_n, sd_cas_n, sd_we_n} === 3'b111, "R1 cmd", 64'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
    chk({rd_rdy, rd_done, req_ack} === 3'b000, "R1 flags", 64'({rd_rdy, rd_done, req_ack}), 0);

    for (int k = 0; k < 10; k++)
      run_vec(VEC[k][31], VEC[k][30:28], VEC[k][27:26], VEC[k][25:1], VEC[k][0], 0);

    run_vec(1'b1, 3'b010, 2'd3, 25'h0F0F0F3, 1'b0, 1);
    run_vec(1'b0, 3'b111, 2'd1, 25'h0000080, 1'b0, 1);

    step(); req = 1; cfg_wide = 1; cfg_mux = 3'b000; cfg_trp = 0; addr = 25'h0000321; #7;
    chk(req_ack === 1'b1, "R2 ack", 64'(req_ack), 1);
    step(); req = 0; step(); step(); rst_n = 0; #7;
    chk({sd_ras_n, sd_cas_n, sd_we_n} === 3'b111, "R1 midburst", 64'({sd_ras_n, sd_cas_n, sd_we_n}), 7);
    chk({rd_rdy, rd_done} === 2'b00, "R1 midburst flags", 64'({rd_rdy, rd_done}), 0);
    step(); rst_n = 1; #7;
    chk({sd_ras_n, sd_cas_n, rd_rdy} === 3'b110, "R1 after", 64'({sd_ras_n, sd_cas_n, rd_rdy}), 6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule